// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by walking a four-level radix tree of 8-byte table entries held in memory. A root frame number gives the first table. Each level uses one 9-bit slice of the virtual address to pick an entry. The 40-bit frame number in that entry leads to the next table, or at the last level to the 4 KB page itself. The 12-bit page offset passes through unchanged.

At each level the walker checks the present flag. It also folds the entry's write, user and no-execute flags into a running set of rights, and checks the request against that set. If a check fails, the walk stops and the walker reports the level that failed. An entry that passes its checks but has a clear reference flag is written back to the same address with the flag set before the walk moves on. For a write request, the final entry also gets its dirty flag set in that same write-back.

The walker serves one translation at a time over a single request/acknowledge memory port.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `mem_req` and `resp_valid` are low.
- R2: A request is taken only while `busy` is low. `busy` stays high from the cycle after acceptance through the response cycle. A `req_valid` seen while busy is ignored and does not change the translation under way.
- R3: The walk issues up to four reads in level order. Level k (k = 1..4) reads address frame*4096 + idx*8. Here idx is virtual address bits [47-9(k-1) : 39-9(k-1)]. The frame is `root_ppn` for level 1, and bits 51:12 of the previous entry for later levels.
- R4: An entry with bit 0 clear ends the walk. The response has `resp_fault`=1 and `resp_perm`=0, and `resp_level` gives the level (0 = level 1 ... 3 = level 4). No further memory access follows.
- R5: Request kinds are 00 read, 01 write and 10 fetch. A write needs bit 1 set in every entry read so far. A user request (`req_user`=1) needs bit 2 set in every entry read so far. A fetch needs bit 63 clear in every entry read so far. The first entry at which this fails ends the walk with `resp_fault`=1, `resp_perm`=1 and that entry's level.
- R6: An entry that passes the checks with bit 5 clear is rewritten once, at its own address, with bit 5 set, before the next read. An entry that already has bit 5 set causes no write.
- R7: On a write request, a level-4 entry with bit 6 clear gets bit 6 and bit 5 set in a single write. Bit 6 is never changed at levels 1 to 3, and never changed for reads or fetches.
- R8: A successful walk returns `resp_ppn` equal to bits 51:12 of the level-4 entry, and `resp_paddr` = {`resp_ppn`, virtual address bits 11:0}.
- R9: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`. Read data is taken in the `mem_ack` cycle.
- R10: `resp_valid` is a one-cycle pulse. The entry at which a walk faults is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_user | input | 1 | Request made at user privilege |
| root_ppn | input | 40 | Frame number of the level-1 table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 52 | Physical byte address of the entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 64 | Entry value read, valid with `mem_ack` |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_perm | output | 1 | Fault was a rights violation (0: entry not present) |
| resp_level | output | 2 | Level of the fault, 0 = level 1 |
| resp_ppn | output | 40 | Translated frame number |
| resp_paddr | output | 52 | Translated physical address |

## Verification
The bench builds the walker with its default widths: four levels of 9-bit indices, a 12-bit offset and 40-bit frame numbers. Every field slice of the virtual address can therefore be reached, and so can the full 52-bit entry address. The chosen frame numbers set bits near the top of the 40-bit field, so a truncated base or a misplaced index shows up in the captured read addresses. The memory model acknowledges every access one cycle late. This keeps each request held across a cycle, and lets faults, reference updates and the single dirty update be placed on each of the four levels.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

  localparam int PTE_W   = 64;
  // Entry flag positions, decoded by the walker
  localparam int B_PRES  = 0;
  localparam int B_RW    = 1;
  localparam int B_US    = 2;
  localparam int B_REF   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_NX    = 63;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_UPDATE,
    S_DONE,
    S_FAULT
  } walk_state_e;

  typedef struct packed {
    logic wr_ok;
    logic usr_ok;
    logic nx;
  } rights_t;

  localparam rights_t RIGHTS_OPEN = '{wr_ok: 1'b1, usr_ok: 1'b1, nx: 1'b0};

  // Fold one entry's flags into the rights collected on the way down
  function automatic rights_t rights_merge(rights_t acc, logic rw, logic us, logic nx);
    rights_t r;
    r.wr_ok  = acc.wr_ok & rw;
    r.usr_ok = acc.usr_ok & us;
    r.nx     = acc.nx | nx;
    return r;
  endfunction

  function automatic logic rights_deny(rights_t r, logic [1:0] kind, logic user);
    logic d;
    d = 1'b0;
    if (kind == ACC_WRITE && !r.wr_ok) d = 1'b1;
    if (kind == ACC_FETCH && r.nx)     d = 1'b1;
    if (user && !r.usr_ok)             d = 1'b1;
    return d;
  endfunction

  function automatic logic mark_needed(logic [PTE_W-1:0] pte, logic want_dirty);
    return !pte[B_REF] || (want_dirty && !pte[B_DIRTY]);
  endfunction

  function automatic logic [PTE_W-1:0] mark_entry(logic [PTE_W-1:0] pte, logic want_dirty);
    logic [PTE_W-1:0] m;
    m = pte;
    m[B_REF] = 1'b1;
    if (want_dirty) m[B_DIRTY] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ptw_va_split.sv
`timescale 1ns/1ps
module ptw_va_split #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [LEVELS*IDX_W-1:0] idx_bits,
  input  logic [LVL_W-1:0]        lvl,
  output logic [IDX_W-1:0]        idx
);

  logic [IDX_W-1:0] fields [LEVELS];

  // Level 1 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign fields[g] = idx_bits[LEVELS*IDX_W-1-g*IDX_W -: IDX_W];
  end

  assign idx = fields[lvl];

endmodule

// File: rtl/ptw_rights.sv
`timescale 1ns/1ps
module ptw_rights
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic       pte_rw,
  input  logic       pte_us,
  input  logic       pte_nx,
  input  logic [1:0] kind,
  input  logic       user,
  output logic       deny
);

  rights_t acc_q;
  rights_t merged;

  always_comb begin
    merged = rights_merge(acc_q, pte_rw, pte_us, pte_nx);
    deny   = rights_deny(merged, kind, user);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= RIGHTS_OPEN;
    else if (clear) acc_q <= RIGHTS_OPEN;
    else if (load)  acc_q <= merged;
  end

endmodule

// File: rtl/ptw_mark.sv
`timescale 1ns/1ps
module ptw_mark
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             at_leaf,
  input  logic             is_write,
  output logic             need,
  output logic [PTE_W-1:0] marked
);

  logic want_dirty;

  always_comb begin
    want_dirty = at_leaf && is_write;
    need       = mark_needed(pte, want_dirty);
    marked     = mark_entry(pte, want_dirty);
  end

endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 40,
  localparam int VA_W   = LEVELS*IDX_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ENT_SH = $clog2(PTE_W/8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic             resp_perm,
  output logic [LVL_W-1:0] resp_level,
  output logic [PPN_W-1:0] resp_ppn,
  output logic [PA_W-1:0]  resp_paddr
);

  // Byte address of entry ix in the table held in frame tbl
  function automatic logic [PA_W-1:0] entry_addr(logic [PPN_W-1:0] tbl, logic [IDX_W-1:0] ix);
    logic [PA_W-1:0] a;
    a = {tbl, {OFF_W{1'b0}}};
    a[ENT_SH +: IDX_W] = ix;
    return a;
  endfunction

  function automatic logic [PPN_W-1:0] entry_base(logic [PTE_W-1:0] pte);
    return pte[PA_W-1:OFF_W];
  endfunction

  walk_state_e      st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] base_q;
  logic [PPN_W-1:0] ppn_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic             user_q;
  logic [PTE_W-1:0] upd_q;
  logic             perm_q;
  logic [LVL_W-1:0] flvl_q;

  // Named internal events, also observed by the checker
  logic             accept;
  logic             lvl_last;
  logic             ev_rd_ack;
  logic             ev_upd_ack;
  logic             ev_absent;
  logic             ev_deny;
  logic             ev_mark;
  logic             ev_step;
  logic             rights_bad;
  logic             mark_need;
  logic [PTE_W-1:0] marked;
  logic [IDX_W-1:0] cur_idx;
  logic [PPN_W-1:0] step_base;

  ptw_va_split #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_split (
    .idx_bits (va_q[VA_W-1:OFF_W]),
    .lvl      (lvl_q),
    .idx      (cur_idx)
  );

  ptw_rights u_rights (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .load   (ev_rd_ack && mem_rdata[B_PRES]),
    .pte_rw (mem_rdata[B_RW]),
    .pte_us (mem_rdata[B_US]),
    .pte_nx (mem_rdata[B_NX]),
    .kind   (kind_q),
    .user   (user_q),
    .deny   (rights_bad)
  );

  ptw_mark u_mark (
    .pte      (mem_rdata),
    .at_leaf  (lvl_last),
    .is_write (kind_q == ACC_WRITE),
    .need     (mark_need),
    .marked   (marked)
  );

  always_comb begin
    accept     = (st_q == S_IDLE) && req_valid;
    lvl_last   = (lvl_q == LVL_W'(LEVELS-1));
    ev_rd_ack  = (st_q == S_READ) && mem_ack;
    ev_upd_ack = (st_q == S_UPDATE) && mem_ack;
    ev_absent  = ev_rd_ack && !mem_rdata[B_PRES];
    ev_deny    = ev_rd_ack && mem_rdata[B_PRES] && rights_bad;
    ev_mark    = ev_rd_ack && mem_rdata[B_PRES] && !rights_bad && mark_need;
    ev_step    = (ev_rd_ack && mem_rdata[B_PRES] && !rights_bad && !mark_need) || ev_upd_ack;
    step_base  = (st_q == S_UPDATE) ? entry_base(upd_q) : entry_base(mem_rdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      lvl_q  <= '0;
      base_q <= '0;
      ppn_q  <= '0;
      va_q   <= '0;
      kind_q <= ACC_READ;
      user_q <= 1'b0;
      upd_q  <= '0;
      perm_q <= 1'b0;
      flvl_q <= '0;
    end else begin
      if (accept) begin
        st_q   <= S_READ;
        lvl_q  <= '0;
        base_q <= root_ppn;
        va_q   <= req_vaddr;
        kind_q <= req_kind;
        user_q <= req_user;
      end else if (ev_absent || ev_deny) begin
        st_q   <= S_FAULT;
        perm_q <= ev_deny;
        flvl_q <= lvl_q;
      end else if (ev_mark) begin
        st_q  <= S_UPDATE;
        upd_q <= marked;
      end else if (ev_step) begin
        if (lvl_last) begin
          st_q  <= S_DONE;
          ppn_q <= step_base;
        end else begin
          st_q   <= S_READ;
          base_q <= step_base;
          lvl_q  <= lvl_q + LVL_W'(1);
        end
      end else if (st_q == S_DONE || st_q == S_FAULT) begin
        st_q <= S_IDLE;
      end
    end
  end

  always_comb begin
    busy       = (st_q != S_IDLE);
    mem_req    = (st_q == S_READ) || (st_q == S_UPDATE);
    mem_we     = (st_q == S_UPDATE);
    mem_addr   = entry_addr(base_q, cur_idx);
    mem_wdata  = (st_q == S_UPDATE) ? upd_q : '0;
    resp_valid = (st_q == S_DONE) || (st_q == S_FAULT);
    resp_fault = (st_q == S_FAULT);
    resp_perm  = (st_q == S_FAULT) && perm_q;
    resp_level = (st_q == S_FAULT) ? flvl_q : '0;
    resp_ppn   = (st_q == S_DONE) ? ppn_q : '0;
    resp_paddr = (st_q == S_DONE) ? {ppn_q, va_q[OFF_W-1:0]} : '0;
  end

endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk #(
  parameter int PA_W = 52
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [PA_W-1:0]  mem_addr,
  input logic [63:0]      mem_wdata,
  input logic             rd_dirty,
  input logic             resp_valid,
  input logic             resp_fault,
  input logic             resp_perm,
  input logic             ev_absent,
  input logic             ev_deny,
  input logic             lvl_last
);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r6_update_same_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> mem_req && mem_addr == $past(mem_addr));

  a_r6_update_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5]);

  a_r7_upper_dirty_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) && !lvl_last |-> mem_wdata[6] == $past(rd_dirty));

  a_r4_absent_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_absent |=> resp_valid && resp_fault && !resp_perm && !mem_req);

  a_r5_deny_reports: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deny |=> resp_valid && resp_fault && resp_perm && !mem_req);

  a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r2_busy_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> busy && !mem_req);

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .rd_dirty   (mem_rdata[ptw_pkg::B_DIRTY]),
  .resp_valid (resp_valid),
  .resp_fault (resp_fault),
  .resp_perm  (resp_perm),
  .ev_absent  (ev_absent),
  .ev_deny    (ev_deny),
  .lvl_last   (lvl_last)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;

  localparam logic [63:0] F_P  = 64'h1;
  localparam logic [63:0] F_RW = 64'h2;
  localparam logic [63:0] F_US = 64'h4;
  localparam logic [63:0] F_A  = 64'h20;
  localparam logic [63:0] F_D  = 64'h40;
  localparam logic [63:0] F_NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OK   = F_P | F_RW | F_US;

  localparam logic [39:0] ROOT = 40'hA0_0000_0010;
  localparam logic [39:0] T1   = 40'h00_0000_0201;
  localparam logic [39:0] T2   = 40'hFF_FFFF_F002;
  localparam logic [39:0] T3   = 40'h12_3456_7003;
  localparam logic [39:0] PG   = 40'hC0_FFEE_1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_vaddr = '0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_user = 1'b0;
  logic [39:0] root_ppn = ROOT;
  logic        busy, mem_req, mem_we, mem_ack;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        resp_valid, resp_fault, resp_perm;
  logic [1:0]  resp_level;
  logic [39:0] resp_ppn;
  logic [51:0] resp_paddr;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .root_ppn(root_ppn), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_perm(resp_perm), .resp_level(resp_level),
    .resp_ppn(resp_ppn), .resp_paddr(resp_paddr)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [63:0] mem_m [longint unsigned];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [63:0] rd_log [8];

  logic        g_fault, g_perm, g_pulse, g_busy;
  logic [1:0]  g_level;
  logic [39:0] g_ppn;
  logic [51:0] g_paddr;

  function automatic logic [8:0] ix(logic [47:0] va, int k);
    return 9'((va >> (39 - 9*k)) & 48'h1FF);
  endfunction

  function automatic logic [63:0] ea(logic [39:0] tbl, logic [8:0] i);
    return (64'(tbl) << 12) | (64'(i) << 3);
  endfunction

  function automatic logic [63:0] mk(logic [39:0] ppn, logic [63:0] f);
    return f | (64'(ppn) << 12);
  endfunction

  function automatic logic [63:0] peek(logic [63:0] a);
    return mem_m.exists(a) ? mem_m[a] : 64'h0;
  endfunction

  // Memory model: acknowledges each request one cycle after it appears
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem_m[64'(mem_addr)] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = peek(64'(mem_addr));
          if (rd_cnt < 8) rd_log[rd_cnt] = 64'(mem_addr);
          rd_cnt++;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] va, input logic [63:0] f0, input logic [63:0] f1,
                       input logic [63:0] f2, input logic [63:0] f3);
    mem_m.delete();
    mem_m[ea(ROOT, ix(va, 0))] = mk(T1, f0);
    mem_m[ea(T1,   ix(va, 1))] = mk(T2, f1);
    mem_m[ea(T2,   ix(va, 2))] = mk(T3, f2);
    mem_m[ea(T3,   ix(va, 3))] = mk(PG, f3);
  endtask

  task automatic walk(input logic [47:0] va, input logic [1:0] kind, input logic usr,
                      input logic jam);
    int n;
    rd_cnt = 0;
    wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = usr;
    @(negedge clk);
    g_busy = busy;
    if (jam) begin
      req_vaddr = va ^ 48'h0040_2010_0000;
      req_kind  = 2'b01;
      req_user  = 1'b1;
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    while (!resp_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    if (n >= 300) check("R10 response timeout", 64'h0, 64'h1);
    g_fault = resp_fault; g_perm = resp_perm; g_level = resp_level;
    g_ppn = resp_ppn; g_paddr = resp_paddr;
    @(negedge clk);
    g_pulse = resp_valid;
  endtask

  task automatic t_reset;
    check("R1 busy after reset", 64'(busy), 64'h0);
    check("R1 mem_req after reset", 64'(mem_req), 64'h0);
    check("R1 resp_valid after reset", 64'(resp_valid), 64'h0);
  endtask

  task automatic t_plain_read;
    logic [47:0] va = 48'h7F3A_5C96_1ABC;
    build(va, OK|F_A, OK|F_A, OK|F_A, OK|F_A);
    walk(va, 2'b00, 1'b0, 1'b0);
    check("R2 busy after accept", 64'(g_busy), 64'h1);
    check("R8 no fault", 64'(g_fault), 64'h0);
    check("R8 ppn", 64'(g_ppn), 64'(PG));
    check("R8 paddr", 64'(g_paddr), {12'h0, PG, va[11:0]});
    check("R3 read count", 64'(rd_cnt), 64'd4);
    check("R6 no write when ref set", 64'(wr_cnt), 64'd0);
    check("R3 R9 level1 address", rd_log[0], ea(ROOT, ix(va, 0)));
    check("R3 R9 level2 address", rd_log[1], ea(T1, ix(va, 1)));
    check("R3 R9 level3 address", rd_log[2], ea(T2, ix(va, 2)));
    check("R3 R9 level4 address", rd_log[3], ea(T3, ix(va, 3)));
    check("R10 one-cycle pulse", 64'(g_pulse), 64'h0);
  endtask

  task automatic t_ref_update;
    logic [47:0] va = 48'h0123_4567_89AB;
    build(va, OK, OK, OK, OK);
    walk(va, 2'b00, 1'b1, 1'b0);
    check("R6 ref write per level", 64'(wr_cnt), 64'd4);
    check("R6 level1 ref", peek(ea(ROOT, ix(va, 0))), mk(T1, OK|F_A));
    check("R6 level2 ref", peek(ea(T1, ix(va, 1))), mk(T2, OK|F_A));
    check("R6 level3 ref", peek(ea(T2, ix(va, 2))), mk(T3, OK|F_A));
    check("R7 read leaves dirty clear", peek(ea(T3, ix(va, 3))), mk(PG, OK|F_A));
    check("R8 ppn after updates", 64'(g_ppn), 64'(PG));
  endtask

  task automatic t_dirty;
    logic [47:0] va = 48'hFFFF_0000_F00D;
    build(va, OK, OK|F_A, OK|F_A, OK);
    walk(va, 2'b01, 1'b1, 1'b0);
    check("R7 writes", 64'(wr_cnt), 64'd2);
    check("R7 leaf ref+dirty", peek(ea(T3, ix(va, 3))), mk(PG, OK|F_A|F_D));
    check("R7 upper dirty untouched", peek(ea(ROOT, ix(va, 0))), mk(T1, OK|F_A));
    check("R8 write walk paddr", 64'(g_paddr), {12'h0, PG, va[11:0]});
    build(va, OK|F_A, OK|F_A, OK|F_A, OK|F_A|F_D);
    walk(va, 2'b01, 1'b0, 1'b0);
    check("R7 no write when dirty set", 64'(wr_cnt), 64'd0);
  endtask

  task automatic t_absent;
    logic [47:0] va = 48'h5555_AAAA_0444;
    build(va, OK|F_A, OK|F_A, (OK & ~F_P)|F_A, OK|F_A);
    walk(va, 2'b00, 1'b0, 1'b0);
    check("R4 fault", 64'(g_fault), 64'h1);
    check("R4 not a rights fault", 64'(g_perm), 64'h0);
    check("R4 level", 64'(g_level), 64'd2);
    check("R4 reads stop", 64'(rd_cnt), 64'd3);
    check("R4 no write", 64'(wr_cnt), 64'd0);
  endtask

  task automatic t_deny_write;
    logic [47:0] va = 48'h3210_FEDC_B987;
    build(va, OK, OK & ~F_RW, OK|F_A, OK|F_A);
    walk(va, 2'b01, 1'b0, 1'b0);
    check("R5 write denied", 64'(g_perm), 64'h1);
    check("R5 write deny level", 64'(g_level), 64'd1);
    check("R5 write deny reads", 64'(rd_cnt), 64'd2);
    check("R10 only level1 updated", 64'(wr_cnt), 64'd1);
    check("R10 faulting entry kept", peek(ea(T1, ix(va, 1))), mk(T2, OK & ~F_RW));
    walk(va, 2'b00, 1'b1, 1'b0);
    check("R5 read allowed without rw", 64'(g_fault), 64'h0);
  endtask

  task automatic t_deny_user;
    logic [47:0] va = 48'h0000_8001_2FFF;
    build(va, OK|F_A, OK|F_A, OK|F_A, (OK & ~F_US)|F_A);
    walk(va, 2'b00, 1'b1, 1'b0);
    check("R5 user denied", 64'({g_fault, g_perm}), 64'h3);
    check("R5 user deny level", 64'(g_level), 64'd3);
    walk(va, 2'b00, 1'b0, 1'b0);
    check("R5 supervisor allowed", 64'(g_fault), 64'h0);
  endtask

  task automatic t_deny_fetch;
    logic [47:0] va = 48'hABCD_EF01_2345;
    build(va, OK|F_A|F_NX, OK|F_A, OK|F_A, OK|F_A);
    walk(va, 2'b10, 1'b0, 1'b0);
    check("R5 fetch denied", 64'({g_fault, g_perm}), 64'h3);
    check("R5 fetch deny level", 64'(g_level), 64'd0);
    check("R5 fetch deny reads", 64'(rd_cnt), 64'd1);
    walk(va, 2'b01, 1'b1, 1'b0);
    check("R5 write ignores nx", 64'(g_fault), 64'h0);
  endtask

  task automatic t_busy_ignore;
    logic [47:0] va = 48'h1111_2222_3333;
    build(va, OK|F_A, OK|F_A, OK|F_A, OK|F_A);
    walk(va, 2'b00, 1'b0, 1'b1);
    check("R2 first request kept", 64'(g_paddr), {12'h0, PG, va[11:0]});
    check("R2 no extra reads", 64'(rd_cnt), 64'd4);
    check("R2 no writes from ignored request", 64'(wr_cnt), 64'd0);
    repeat (3) @(negedge clk);
    check("R2 idle afterwards", 64'(busy), 64'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_read();
    t_ref_update();
    t_dirty();
    t_absent();
    t_deny_write();
    t_deny_user();
    t_deny_fetch();
    t_busy_ignore();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule